// File: doc/BRIEF.md
# Indirect Addressing Pointer Unit

The unit holds a small bank of 12-bit data-memory pointers. Each pointer is stored as an 8-bit low byte and a 4-bit high part. The CPU reaches each pointer through a group of operand addresses in the special-register page. Five of these are virtual operands that cause an indirect access to data memory:
- plain access with no change to the pointer
- post-decrement
- post-increment
- pre-increment
- offset access, which adds the signed 8-bit working register for that access only

Two more addresses expose the pointer's low and high bytes as ordinary registers.

On each strobe the unit decodes the register address and forms the effective 12-bit address. It then does one of three things:
- drives the data-memory port;
- resolves one of the special cases where the effective address lands on a virtual operand or a pointer register;
- schedules the pointer's automatic update for the clock edge that ends the access.

The update never produces any condition flag. Read data comes back in the same cycle as the strobe.

Top module: `ptr_unit`

## Requirements
- R1: After reset every pointer reads back as 000h through its low and high byte addresses.
- R2: Pointer n (0..2) owns register addresses E0h+8n+k. k=5 is the low byte and k=6 the high part. Direct reads and writes there act only on that byte and touch no RAM. The high part keeps 4 bits, and its upper 4 read bits are zero. k=7 is unmapped.
- R3: A read or write at k=0 accesses RAM at the pointer value and leaves the pointer unchanged.
- R4: k=1 (post-decrement) and k=2 (post-increment) access RAM at the current value. At the ending edge they subtract or add 1 across all 12 bits, with carry and borrow between low and high and wrap modulo 4096.
- R5: k=3 (pre-increment) accesses RAM at pointer+1, and the pointer becomes pointer+1.
- R6: k=4 accesses RAM at pointer plus the sign-extended working register, modulo 4096. No pointer changes.
- R7: If the effective address is F00h plus any operand address with k=0..4, a read returns 00h, no RAM access happens, and the auto-modify of the accessing pointer still applies.
- R8: If the effective address is F00h plus a pointer byte address (k=5 or 6), no RAM access happens. A write stores the data into that byte and suppresses the auto-modify. A read returns that byte, and the auto-modify applies.
- R9: When read and write strobes are both high, the cycle is a write only, and read data is 00h.
- R10: Read data of a virtual operand is valid combinationally in the strobe cycle. With no strobe, or at an unmapped address, read data is 00h and the RAM port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 8 | Special-register address of the access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| wreg | input | 8 | Working register value used as signed offset |
| rd_data | output | 8 | Read data |
| ram_addr | output | 12 | Data-memory address (effective address) |
| ram_en | output | 1 | Data-memory access enable |
| ram_we | output | 1 | Data-memory write enable |
| ram_wdata | output | 8 | Data-memory write data |
| ram_rdata | input | 8 | Data-memory read data, valid in the same cycle |

## Verification
The hardest situations to reach are those where a pointer's effective address falls inside the operand window at the top of the address space. In some of these the pointer targets its own or another pointer's byte registers, so a write must redirect into the pointer bank and suppress the increment. The stimulus loads pointers directly with values in the FE0h–FF7h range, covering every slot, before using every operand kind. A long run of mixed operations then keeps steering pointers back into that window. Carry and borrow across the low/high boundary and the wrap at 000h/FFFh are set up the same way, by loading FFh-ended and boundary values directly.

// File: rtl/ptr_unit_pkg.sv
`timescale 1ns/1ps
package ptr_unit_pkg;

  typedef enum logic [2:0] {
    SLOT_PLAIN   = 3'd0,
    SLOT_POSTDEC = 3'd1,
    SLOT_POSTINC = 3'd2,
    SLOT_PREINC  = 3'd3,
    SLOT_OFFSET  = 3'd4,
    SLOT_LOW     = 3'd5,
    SLOT_HIGH    = 3'd6,
    SLOT_GAP     = 3'd7
  } slot_e;

  localparam int SLOTS_PER_PTR = 8;

  function automatic logic slot_is_virtual(slot_e s);
    return (s == SLOT_PLAIN) || (s == SLOT_POSTDEC) || (s == SLOT_POSTINC) ||
           (s == SLOT_PREINC) || (s == SLOT_OFFSET);
  endfunction

  function automatic logic slot_modifies(slot_e s);
    return (s == SLOT_POSTDEC) || (s == SLOT_POSTINC) || (s == SLOT_PREINC);
  endfunction

endpackage

// File: rtl/ptr_slot_decode.sv
`timescale 1ns/1ps
module ptr_slot_decode
  import ptr_unit_pkg::*;
#(
  parameter int              N_PTR    = 3,
  parameter int              RA_W     = 8,
  parameter logic [RA_W-1:0] MAP_BASE = 8'hE0,
  parameter int              IDX_W    = 2
) (
  input  logic [RA_W-1:0]  addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output slot_e            slot
);
  localparam int SPAN = N_PTR * SLOTS_PER_PTR;

  logic [RA_W-1:0] off;

  always_comb begin
    off  = addr - MAP_BASE;
    slot = slot_e'(off[2:0]);
    idx  = off[IDX_W+2:3];
    hit  = (addr >= MAP_BASE) && (int'(off) < SPAN) && (slot != SLOT_GAP);
  end
endmodule

// File: rtl/ptr_agu.sv
`timescale 1ns/1ps
module ptr_agu
  import ptr_unit_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic [AW-1:0] ptr,
  input  slot_e         slot,
  input  logic [DW-1:0] wreg,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] sext;
  logic [AW-1:0] plus1;
  logic [AW-1:0] minus1;

  always_comb begin
    sext   = {{(AW-DW){wreg[DW-1]}}, wreg};
    plus1  = ptr + AW'(1);
    minus1 = ptr - AW'(1);
    unique case (slot)
      SLOT_PREINC: ea = plus1;
      SLOT_OFFSET: ea = ptr + sext;
      default:     ea = ptr;
    endcase
    unique case (slot)
      SLOT_POSTDEC:             nxt = minus1;
      SLOT_POSTINC, SLOT_PREINC: nxt = plus1;
      default:                  nxt = ptr;
    endcase
  end
endmodule

// File: rtl/ptr_bank.sv
`timescale 1ns/1ps
module ptr_bank #(
  parameter int N_PTR = 3,
  parameter int AW    = 12,
  parameter int DW    = 8,
  localparam int HI_W = AW - DW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_PTR-1:0]            lo_we,
  input  logic [N_PTR-1:0]            hi_we,
  input  logic [N_PTR-1:0][DW-1:0]    lo_d,
  input  logic [N_PTR-1:0][HI_W-1:0]  hi_d,
  output logic [N_PTR-1:0][AW-1:0]    ptr_q
);
  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    logic [DW-1:0]   lo_q, lo_nx;
    logic [HI_W-1:0] hi_q, hi_nx;

    always_comb begin
      lo_nx = lo_we[g] ? lo_d[g] : lo_q;
      hi_nx = hi_we[g] ? hi_d[g] : hi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        lo_q <= lo_nx;
        hi_q <= hi_nx;
      end
    end

    assign ptr_q[g] = {hi_q, lo_q};
  end
endmodule

// File: rtl/ptr_unit.sv
`timescale 1ns/1ps
module ptr_unit
  import ptr_unit_pkg::*;
#(
  parameter int                   N_PTR    = 3,
  parameter int                   AW       = 12,
  parameter int                   DW       = 8,
  parameter int                   RA_W     = 8,
  parameter logic [RA_W-1:0]      MAP_BASE = 8'hE0,
  parameter logic [AW-RA_W-1:0]   SFR_PAGE = 4'hF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] reg_addr,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW-1:0]   wreg,
  output logic [DW-1:0]   rd_data,
  output logic [AW-1:0]   ram_addr,
  output logic            ram_en,
  output logic            ram_we,
  output logic [DW-1:0]   ram_wdata,
  input  logic [DW-1:0]   ram_rdata
);
  localparam int HI_W  = AW - DW;
  localparam int IDX_W = (N_PTR > 1) ? $clog2(N_PTR) : 1;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // access qualification
  logic do_wr, do_rd;
  assign do_wr = wr_en;
  assign do_rd = rd_en & ~wr_en;

  // decode of the CPU register address
  logic             hit_a;
  logic [IDX_W-1:0] idx_a;
  slot_e            slot_a;

  ptr_slot_decode #(.N_PTR(N_PTR), .RA_W(RA_W), .MAP_BASE(MAP_BASE), .IDX_W(IDX_W))
    i_dec_reg (.addr(reg_addr), .hit(hit_a), .idx(idx_a), .slot(slot_a));

  logic [N_PTR-1:0][AW-1:0] ptr_q;
  logic [AW-1:0]            cur_ptr;

  always_comb begin
    cur_ptr = '0;
    for (int n = 0; n < N_PTR; n++) begin
      if (idx_a == IDX_W'(n)) cur_ptr = ptr_q[n];
    end
  end

  // effective address and auto-modified value
  logic [AW-1:0] ea, nxt;

  ptr_agu #(.AW(AW), .DW(DW))
    i_agu (.ptr(cur_ptr), .slot(slot_a), .wreg(wreg), .ea(ea), .nxt(nxt));

  // decode of the effective address against the operand window
  logic             hit_e_raw;
  logic [IDX_W-1:0] idx_e;
  slot_e            slot_e_q;

  ptr_slot_decode #(.N_PTR(N_PTR), .RA_W(RA_W), .MAP_BASE(MAP_BASE), .IDX_W(IDX_W))
    i_dec_ea (.addr(ea[RA_W-1:0]), .hit(hit_e_raw), .idx(idx_e), .slot(slot_e_q));

  logic          ea_hit, ea_virt, ea_preg, indirect;
  logic [AW-1:0] tgt_ptr;

  always_comb begin
    indirect = (do_wr | do_rd) & hit_a & slot_is_virtual(slot_a);
    ea_hit   = (ea[AW-1:RA_W] == SFR_PAGE) & hit_e_raw;
    ea_virt  = ea_hit & slot_is_virtual(slot_e_q);
    ea_preg  = ea_hit & ~slot_is_virtual(slot_e_q);
    tgt_ptr  = '0;
    for (int n = 0; n < N_PTR; n++) begin
      if (idx_e == IDX_W'(n)) tgt_ptr = ptr_q[n];
    end
  end

  // data-memory port
  always_comb begin
    ram_en    = indirect & ~ea_virt & ~ea_preg;
    ram_we    = ram_en & do_wr;
    ram_addr  = ea;
    ram_wdata = wr_data;
  end

  // read data path
  always_comb begin
    rd_data = '0;
    if (do_rd && hit_a) begin
      if (slot_a == SLOT_LOW) begin
        rd_data = cur_ptr[DW-1:0];
      end else if (slot_a == SLOT_HIGH) begin
        rd_data = DW'(cur_ptr[AW-1:DW]);
      end else if (ea_virt) begin
        rd_data = '0;
      end else if (ea_preg) begin
        rd_data = (slot_e_q == SLOT_LOW) ? tgt_ptr[DW-1:0] : DW'(tgt_ptr[AW-1:DW]);
      end else begin
        rd_data = ram_rdata;
      end
    end
  end

  // pointer byte write enables
  logic [N_PTR-1:0]           lo_we, hi_we;
  logic [N_PTR-1:0][DW-1:0]   lo_d;
  logic [N_PTR-1:0][HI_W-1:0] hi_d;

  for (genvar g = 0; g < N_PTR; g++) begin : g_upd
    logic sel_a, sel_e, dir_lo, dir_hi, ind_lo, ind_hi, auto_mod;

    always_comb begin
      sel_a    = hit_a  && (idx_a == IDX_W'(g));
      sel_e    = ea_hit && (idx_e == IDX_W'(g));
      dir_lo   = do_wr & sel_a & (slot_a == SLOT_LOW);
      dir_hi   = do_wr & sel_a & (slot_a == SLOT_HIGH);
      ind_lo   = do_wr & indirect & ea_preg & sel_e & (slot_e_q == SLOT_LOW);
      ind_hi   = do_wr & indirect & ea_preg & sel_e & (slot_e_q == SLOT_HIGH);
      auto_mod = indirect & sel_a & slot_modifies(slot_a) & ~(do_wr & ea_preg);
      lo_we[g] = dir_lo | ind_lo | auto_mod;
      hi_we[g] = dir_hi | ind_hi | auto_mod;
      lo_d[g]  = auto_mod ? nxt[DW-1:0]  : wr_data;
      hi_d[g]  = auto_mod ? nxt[AW-1:DW] : wr_data[HI_W-1:0];
    end
  end

  ptr_bank #(.N_PTR(N_PTR), .AW(AW), .DW(DW))
    i_bank (.clk(clk), .rst_n(rst_sync_n), .lo_we(lo_we), .hi_we(hi_we),
            .lo_d(lo_d), .hi_d(hi_d), .ptr_q(ptr_q));

endmodule

// File: rtl/ptr_unit_chk.sv
`timescale 1ns/1ps
module ptr_unit_chk #(
  parameter int                 N_PTR    = 3,
  parameter int                 AW       = 12,
  parameter int                 DW       = 8,
  parameter int                 RA_W     = 8,
  parameter logic [RA_W-1:0]    MAP_BASE = 8'hE0,
  parameter logic [AW-RA_W-1:0] SFR_PAGE = 4'hF
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [RA_W-1:0]          reg_addr,
  input logic                     rd_en,
  input logic                     wr_en,
  input logic [DW-1:0]            rd_data,
  input logic [AW-1:0]            ram_addr,
  input logic                     ram_en,
  input logic                     ram_we,
  input logic [N_PTR-1:0][AW-1:0] ptr_q
);
  logic [RA_W-1:0] lowb, rel;
  logic            in_window;
  logic            rd_only;

  always_comb begin
    lowb      = ram_addr[RA_W-1:0];
    rel       = lowb - MAP_BASE;
    in_window = (ram_addr[AW-1:RA_W] == SFR_PAGE) && (lowb >= MAP_BASE) &&
                (int'(rel) < N_PTR * 8) && (rel[2:0] != 3'd7);
    rd_only   = rd_en && !wr_en;
  end

  // R7 / R8: an effective address inside the operand window never reaches RAM
  assert_no_ram_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> !in_window);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |-> (rd_data == '0));

  assert_ram_we_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (wr_en && ram_en));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |-> (!ram_en && rd_data == '0));

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr_chk
    localparam logic [RA_W-1:0] A_PLAIN = MAP_BASE + RA_W'(8*g);
    localparam logic [RA_W-1:0] A_PINC  = MAP_BASE + RA_W'(8*g + 2);
    localparam logic [RA_W-1:0] A_OFFS  = MAP_BASE + RA_W'(8*g + 4);
    localparam logic [RA_W-1:0] A_HIGH  = MAP_BASE + RA_W'(8*g + 6);

    assert_plain_read_keeps_ptrs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && reg_addr == A_PLAIN) |=> $stable(ptr_q));

    assert_offset_read_keeps_ptrs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && reg_addr == A_OFFS) |=> $stable(ptr_q));

    assert_postinc_read_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && reg_addr == A_PINC) |=> (ptr_q[g] == $past(ptr_q[g]) + AW'(1)));

    assert_high_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && reg_addr == A_HIGH) |-> (rd_data[DW-1:AW-DW] == '0));
  end
endmodule

bind ptr_unit ptr_unit_chk #(
  .N_PTR(N_PTR), .AW(AW), .DW(DW), .RA_W(RA_W), .MAP_BASE(MAP_BASE), .SFR_PAGE(SFR_PAGE)
) i_ptr_unit_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .rd_en(rd_en), .wr_en(wr_en),
  .rd_data(rd_data), .ram_addr(ram_addr), .ram_en(ram_en), .ram_we(ram_we), .ptr_q(ptr_q)
);

// File: tb/test_ptr_unit.sv
`timescale 1ns/1ps
module test_ptr_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] reg_addr, wr_data, wreg, rd_data, ram_wdata, ram_rdata;
  logic       rd_en, wr_en, ram_en, ram_we;
  logic [11:0] ram_addr;

  ptr_unit i_ptr_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .wreg(wreg), .rd_data(rd_data), .ram_addr(ram_addr),
    .ram_en(ram_en), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int mp[3];
  logic [7:0] mem[int];
  string force_tag = "";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sx8(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // operand-window decode of an 8-bit address: returns slot or -1
  function automatic int slot_of(input int a, output int n);
    int o;
    n = 0;
    if (a < 224 || a - 224 >= 24) return -1;
    o = a - 224;
    if (o % 8 == 7) return -1;
    n = o / 8;
    return o % 8;
  endfunction

  task automatic op(input bit w, input bit r, input int a, input int d, input int wv);
    int s, n, es, en, p, ea, upd, exp_rd, exp_ea;
    bit isw, isr, exp_ram, exp_we;
    int nmp[3];
    string tag;
    @(negedge clk);
    reg_addr = 8'(a); wr_data = 8'(d); wreg = 8'(wv); wr_en = w; rd_en = r;
    #2;
    ram_rdata = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
    #3;
    nmp = mp;
    isw = w; isr = r && !w;
    exp_rd = 0; exp_ram = 0; exp_we = 0; exp_ea = 0;
    s = slot_of(a, n);
    tag = "R10";
    if (isw || isr) begin
      if (s == 5 || s == 6) begin
        tag = "R2";
        if (isr) exp_rd = (s == 5) ? (mp[n] & 255) : (mp[n] >> 8);
        else if (s == 5) nmp[n] = (mp[n] & 'hF00) | (d & 255);
        else             nmp[n] = (mp[n] & 255) | ((d & 15) << 8);
      end else if (s >= 0) begin
        p = mp[n];
        ea  = (s == 3) ? p + 1 : (s == 4) ? p + sx8(wv) : p;
        ea  = ea & 'hFFF;
        upd = (s == 1) ? p - 1 : (s == 2 || s == 3) ? p + 1 : p;
        upd = upd & 'hFFF;
        es = -1; en = 0;
        if ((ea >> 8) == 'hF) es = slot_of(ea & 255, en);
        if (es >= 0 && es <= 4) begin
          tag = "R7";
          nmp[n] = upd;
        end else if (es == 5 || es == 6) begin
          tag = "R8";
          if (isr) begin
            exp_rd = (es == 5) ? (mp[en] & 255) : (mp[en] >> 8);
            nmp[n] = upd;
          end else if (es == 5) nmp[en] = (mp[en] & 'hF00) | (d & 255);
          else                  nmp[en] = (mp[en] & 255) | ((d & 15) << 8);
        end else begin
          tag = (s == 0) ? "R3" : (s == 3) ? "R5" : (s == 4) ? "R6" : "R4";
          exp_ram = 1; exp_we = isw; exp_ea = ea;
          if (isr) exp_rd = mem.exists(ea) ? int'(mem[ea]) : 0;
          nmp[n] = upd;
        end
      end
      if (w && r) tag = "R9";
    end
    if (force_tag != "") tag = force_tag;
    chk(int'(rd_data) == exp_rd, tag, rd_data, exp_rd);
    chk(ram_en == exp_ram, tag, ram_en, exp_ram);
    chk(ram_we == exp_we, tag, ram_we, exp_we);
    if (exp_ram) chk(int'(ram_addr) == exp_ea, tag, ram_addr, exp_ea);
    if (exp_we)  chk(int'(ram_wdata) == (d & 255), tag, ram_wdata, d & 255);
    @(posedge clk);
    mp = nmp;
    if (exp_we) mem[exp_ea] = 8'(d);
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    #5;
    chk(rd_data == 8'h00 && !ram_en, "R10", {ram_en, rd_data}, 0);
  endtask

  function automatic int A(input int n, input int k);
    return 224 + 8 * n + k;
  endfunction

  task automatic set_ptr(input int n, input int v);
    op(1, 0, A(n, 5), v & 255, 0);
    op(1, 0, A(n, 6), (v >> 8) & 15, 0);
  endtask

  task automatic peek_ptr(input int n);
    op(0, 1, A(n, 5), 0, 0);
    op(0, 1, A(n, 6), 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; rd_en = 0; wr_en = 0; reg_addr = 0; wr_data = 0; wreg = 0; ram_rdata = 0;
    for (int i = 0; i < 3; i++) mp[i] = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: reset state
    force_tag = "R1";
    for (int n = 0; n < 3; n++) peek_ptr(n);
    force_tag = "";

    // R2: direct byte access, high part masked
    set_ptr(0, 'hAB5);
    op(1, 0, A(1, 6), 'hF7, 0);
    for (int n = 0; n < 3; n++) peek_ptr(n);
    idle();

    // R4: post-increment writes, post-decrement reads
    set_ptr(0, 'h100);
    for (int i = 0; i < 4; i++) op(1, 0, A(0, 2), 'h10 + i, 0);
    set_ptr(1, 'h103);
    for (int i = 0; i < 4; i++) op(0, 1, A(1, 1), 0, 0);
    peek_ptr(0); peek_ptr(1);
    // R5 / R3 / R6
    op(0, 1, A(1, 3), 0, 0);
    op(0, 1, A(1, 0), 0, 0);
    set_ptr(2, 'h103);
    op(0, 1, A(2, 4), 0, 'hFD);
    op(0, 1, A(2, 4), 0, 'h7F);
    op(1, 0, A(2, 4), 'h5A, 'h80);
    peek_ptr(2);
    // R4: carry, borrow, wrap
    set_ptr(2, 'h0FF); op(0, 1, A(2, 2), 0, 0); peek_ptr(2);
    op(0, 1, A(2, 1), 0, 0); peek_ptr(2);
    set_ptr(2, 'hFFF); op(1, 0, A(2, 2), 'h66, 0); peek_ptr(2);
    op(0, 1, A(2, 1), 0, 0); peek_ptr(2);
    // R7: pointer aimed at an operand address
    set_ptr(0, 'hFE8);
    op(0, 1, A(0, 0), 0, 0);
    op(1, 0, A(0, 2), 'h99, 0); peek_ptr(0);
    // R8: pointer aimed at another pointer's bytes and its own
    set_ptr(0, 'hFED);
    op(1, 0, A(0, 2), 'h55, 0); peek_ptr(0); peek_ptr(1);
    op(0, 1, A(0, 2), 0, 0); op(0, 1, A(0, 2), 0, 0); peek_ptr(0);
    set_ptr(2, 'hFF5);
    op(1, 0, A(2, 0), 'h33, 0); peek_ptr(2);
    set_ptr(1, 'hFE5);
    op(1, 0, A(1, 4), 'h0C, 'h01); peek_ptr(0); peek_ptr(1);
    // R9: both strobes
    set_ptr(1, 'h200);
    op(1, 1, A(1, 2), 'h77, 0); op(0, 1, A(1, 1), 0, 0); peek_ptr(1);
    // R10: unmapped addresses
    op(0, 1, 'h10, 0, 0); op(1, 0, 'h10, 'h12, 0); op(0, 1, A(0, 7), 0, 0);
    op(1, 0, 'hFF, 'h44, 0); idle();

    // mixed run steering pointers through the window
    for (int i = 0; i < 600; i++) begin
      int n, k, r;
      n = int'($urandom % 3);
      r = int'($urandom % 16);
      if (r == 0) set_ptr(n, 'hFE0 + int'($urandom % 24));
      else if (r == 1) set_ptr(n, int'($urandom % 4096));
      else begin
        k = int'($urandom % 8);
        op(1'($urandom), 1'($urandom), A(n, k), int'($urandom % 256), int'($urandom % 256));
      end
    end
    for (int n = 0; n < 3; n++) peek_ptr(n);
    idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule